// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block tracks every instruction in flight in a speculative out-of-order core, from issue to retirement. Each issued instruction gets the next free slot of a circular buffer, and that slot number goes back to the issue logic as the renaming tag for the instruction's destination. Execution units send their results on up to two result-bus ports, in any order. Each port names its slot by the tag, and the result is parked there. No architectural state changes at that point.

Retirement works from the oldest slot. A slot retires only once its result has arrived. Up to two slots retire per cycle, and always in program order. A retiring register operation drives a register-file write. A retiring store drives a memory write. A retiring branch writes nothing. A branch whose result says it was mispredicted is acted on only when it is the oldest slot. It retires, raises a flush pulse and discards every younger slot, so the next issued instruction takes the slot just after the branch.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` is 1, `alloc_tag` is 0, and `cm_rf_we`, `cm_st_we` and `flush` are all 0.
- R2: The buffer holds at most DEPTH live slots. `alloc_ready` is 0 exactly while DEPTH slots are live. Full and empty stay correct after the pointers wrap.
- R3: An accepted allocation (`alloc_valid` high while `alloc_ready` is 1) receives `alloc_tag` as its tag. Successive allocations receive consecutive slot numbers modulo DEPTH.
- R4: A result on either write port (`wb_valid[p]`, with tag, value, address and mispredict bit) is stored in the tagged slot and marks that slot complete. A result never causes retirement by itself.
- R5: While the oldest slot is incomplete, nothing retires, even if younger slots are complete.
- R6: At most two slots retire per cycle, in program order. The second slot retires only if the first retires in the same cycle, the second is complete, and neither of them is a mispredicted branch. Retirement outputs appear one cycle after the retire decision.
- R7: The kind code is 0 for a register operation, 1 for a store and 2 for a branch. A register operation retires as `cm_rf_we[s]` with its destination and value. A store retires as `cm_st_we[s]` with its address and value, and no register write. A branch retires with neither.
- R8: A mispredicted branch at the oldest slot retires without any write and raises `flush` for exactly one cycle. All younger slots are discarded and never retire. After the flush the buffer is empty, `alloc_ready` is 1, and `alloc_tag` is the slot after the branch. Allocations and results presented in the flush cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Issue logic presents an instruction |
| alloc_kind | input | 2 | Kind code: 0 register op, 1 store, 2 branch |
| alloc_dest | input | REG_W | Destination register number |
| alloc_ready | output | 1 | A slot is free |
| alloc_tag | output | IDX_W | Slot number given to the presented instruction |
| wb_valid | input | WB_PORTS | Result present on each write port |
| wb_tag | input | WB_PORTS*IDX_W | Slot addressed by each port |
| wb_value | input | WB_PORTS*DATA_W | Result value (store data for stores) |
| wb_addr | input | WB_PORTS*ADDR_W | Store address |
| wb_mispredict | input | WB_PORTS | Branch outcome disagreed with prediction |
| cm_rf_we | output | 2 | Register write per retire slot |
| cm_rf_idx | output | 2*REG_W | Register number per retire slot |
| cm_rf_data | output | 2*DATA_W | Register value per retire slot |
| cm_st_we | output | 2 | Memory write per retire slot |
| cm_st_addr | output | 2*ADDR_W | Store address per retire slot |
| cm_st_data | output | 2*DATA_W | Store data per retire slot |
| flush | output | 1 | One-cycle pulse: younger work discarded |

## Verification
The bench completes a full buffer in reverse order, so a design that retires whatever is complete, rather than only the oldest slot, shows a retirement too early or out of order. It places a mispredicted branch directly behind a complete register operation; a design that lets the branch take the second retire slot, or that flushes before the branch is oldest, either loses the older write or lets a discarded store or register write through. It refills the buffer after the pointers have moved mid-range, and an off-by-one in the wrap bit shows up as a wrong tag or as `alloc_ready` dropping at the wrong count.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;
  typedef enum logic [1:0] {
    OP_REG    = 2'd0,
    OP_STORE  = 2'd1,
    OP_BRANCH = 2'd2
  } op_kind_e;
endpackage

// File: rtl/rob_ptrs.sv
`timescale 1ns/1ps
// Head/tail pointers with one wrap bit above the slot index (DEPTH is a power of two).
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [1:0]       pop_i,
  input  logic             flush_i,
  output logic [IDX_W-1:0] head_idx_o,
  output logic [IDX_W-1:0] tail_idx_o,
  output logic [PTR_W-1:0] count_o,
  output logic             full_o
);
  logic [PTR_W-1:0] head_q, tail_q, head_nxt;

  assign head_nxt   = head_q + PTR_W'(pop_i);
  assign head_idx_o = head_q[IDX_W-1:0];
  assign tail_idx_o = tail_q[IDX_W-1:0];
  assign count_o    = tail_q - head_q;
  assign full_o     = (tail_q[IDX_W] != head_q[IDX_W]) &&
                      (tail_q[IDX_W-1:0] == head_q[IDX_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_nxt;
      if (flush_i) tail_q <= head_nxt;
      else         tail_q <= tail_q + PTR_W'(push_i);
    end
  end

  // R2: occupancy never exceeds the capacity
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    count_o <= PTR_W'(DEPTH));
  // R2: retirement never takes more slots than are live
  a_r2_pop_bound: assert property (@(posedge clk) disable iff (rst)
    PTR_W'(pop_i) <= count_o);
endmodule

// File: rtl/rob_entries.sv
`timescale 1ns/1ps
// Slot storage: one allocate write port, WB_PORTS result write ports, two read ports.
module rob_entries #(
  parameter int DEPTH    = 8,
  parameter int REG_W    = 5,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 16,
  parameter int WB_PORTS = 2,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      alloc_we_i,
  input  logic [IDX_W-1:0]          alloc_idx_i,
  input  rob_pkg::op_kind_e         alloc_kind_i,
  input  logic [REG_W-1:0]          alloc_dest_i,
  input  logic [WB_PORTS-1:0]       wb_valid_i,
  input  logic [WB_PORTS*IDX_W-1:0] wb_tag_i,
  input  logic [WB_PORTS*DATA_W-1:0] wb_value_i,
  input  logic [WB_PORTS*ADDR_W-1:0] wb_addr_i,
  input  logic [WB_PORTS-1:0]       wb_misp_i,
  input  logic                      flush_i,
  input  logic [IDX_W-1:0]          rd_idx_i  [2],
  output rob_pkg::op_kind_e         rd_kind_o [2],
  output logic [REG_W-1:0]          rd_dest_o [2],
  output logic [DATA_W-1:0]         rd_val_o  [2],
  output logic [ADDR_W-1:0]         rd_addr_o [2],
  output logic [1:0]                rd_done_o,
  output logic [1:0]                rd_misp_o
);
  rob_pkg::op_kind_e kind_q [DEPTH];
  logic [REG_W-1:0]  dest_q [DEPTH];
  logic [DATA_W-1:0] val_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DEPTH-1:0]  done_q, misp_q;

  always_ff @(posedge clk) begin
    if (alloc_we_i) begin
      kind_q[alloc_idx_i] <= alloc_kind_i;
      dest_q[alloc_idx_i] <= alloc_dest_i;
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < WB_PORTS; p++) begin
      if (wb_valid_i[p]) begin
        val_q[wb_tag_i[p*IDX_W +: IDX_W]]  <= wb_value_i[p*DATA_W +: DATA_W];
        addr_q[wb_tag_i[p*IDX_W +: IDX_W]] <= wb_addr_i[p*ADDR_W +: ADDR_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
      misp_q <= '0;
    end else begin
      if (alloc_we_i) done_q[alloc_idx_i] <= 1'b0;
      for (int p = 0; p < WB_PORTS; p++) begin
        if (wb_valid_i[p]) begin
          done_q[wb_tag_i[p*IDX_W +: IDX_W]] <= 1'b1;
          misp_q[wb_tag_i[p*IDX_W +: IDX_W]] <= wb_misp_i[p];
        end
      end
      if (flush_i) done_q <= '0;
    end
  end

  for (genvar r = 0; r < 2; r++) begin : g_rd
    assign rd_kind_o[r] = kind_q[rd_idx_i[r]];
    assign rd_dest_o[r] = dest_q[rd_idx_i[r]];
    assign rd_val_o[r]  = val_q[rd_idx_i[r]];
    assign rd_addr_o[r] = addr_q[rd_idx_i[r]];
    assign rd_done_o[r] = done_q[rd_idx_i[r]];
    assign rd_misp_o[r] = misp_q[rd_idx_i[r]];
  end
endmodule

// File: rtl/rob_retire.sv
`timescale 1ns/1ps
// Picks up to two oldest complete slots and registers the architectural writes.
module rob_retire #(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  localparam int PTR_W = $clog2(DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PTR_W-1:0]   count_i,
  input  rob_pkg::op_kind_e  kind_i [2],
  input  logic [REG_W-1:0]   dest_i [2],
  input  logic [DATA_W-1:0]  val_i  [2],
  input  logic [ADDR_W-1:0]  addr_i [2],
  input  logic [1:0]         done_i,
  input  logic [1:0]         misp_i,
  output logic [1:0]         pop_o,
  output logic               flush_req_o,
  output logic [1:0]         rf_we_o,
  output logic [2*REG_W-1:0] rf_idx_o,
  output logic [2*DATA_W-1:0] rf_data_o,
  output logic [1:0]         st_we_o,
  output logic [2*ADDR_W-1:0] st_addr_o,
  output logic [2*DATA_W-1:0] st_data_o,
  output logic               flush_o
);
  logic [1:0] bad, go, vld_q;

  always_comb begin
    bad[0] = (kind_i[0] == rob_pkg::OP_BRANCH) && misp_i[0];
    bad[1] = (kind_i[1] == rob_pkg::OP_BRANCH) && misp_i[1];
    go[0]  = (count_i != '0) && done_i[0];
    go[1]  = go[0] && !bad[0] && (count_i >= PTR_W'(2)) && done_i[1] && !bad[1];
    pop_o  = {1'b0, go[0]} + {1'b0, go[1]};
    flush_req_o = go[0] && bad[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we_o <= '0;
      st_we_o <= '0;
      vld_q   <= '0;
      flush_o <= 1'b0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        rf_we_o[s] <= go[s] && (kind_i[s] == rob_pkg::OP_REG);
        st_we_o[s] <= go[s] && (kind_i[s] == rob_pkg::OP_STORE);
      end
      vld_q   <= go;
      flush_o <= flush_req_o;
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_out
    always_ff @(posedge clk) begin
      rf_idx_o[s*REG_W +: REG_W]   <= dest_i[s];
      rf_data_o[s*DATA_W +: DATA_W] <= val_i[s];
      st_addr_o[s*ADDR_W +: ADDR_W] <= addr_i[s];
      st_data_o[s*DATA_W +: DATA_W] <= val_i[s];
    end
  end

  // R8: the discard pulse lasts a single cycle
  a_r8_flush_pulse: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> !flush_o);
  // R8: nothing younger retires once a flush has been raised
  a_r8_quiet_after_flush: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> (vld_q == 2'b00));
endmodule

// File: rtl/rob_core.sv
`timescale 1ns/1ps
module rob_core #(
  parameter int DEPTH    = 8,
  parameter int REG_W    = 5,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 16,
  parameter int WB_PORTS = 2,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int PTR_W   = IDX_W + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       alloc_valid,
  input  logic [1:0]                 alloc_kind,
  input  logic [REG_W-1:0]           alloc_dest,
  output logic                       alloc_ready,
  output logic [IDX_W-1:0]           alloc_tag,
  input  logic [WB_PORTS-1:0]        wb_valid,
  input  logic [WB_PORTS*IDX_W-1:0]  wb_tag,
  input  logic [WB_PORTS*DATA_W-1:0] wb_value,
  input  logic [WB_PORTS*ADDR_W-1:0] wb_addr,
  input  logic [WB_PORTS-1:0]        wb_mispredict,
  output logic [1:0]                 cm_rf_we,
  output logic [2*REG_W-1:0]         cm_rf_idx,
  output logic [2*DATA_W-1:0]        cm_rf_data,
  output logic [1:0]                 cm_st_we,
  output logic [2*ADDR_W-1:0]        cm_st_addr,
  output logic [2*DATA_W-1:0]        cm_st_data,
  output logic                       flush
);
  logic [IDX_W-1:0]  head_idx, tail_idx;
  logic [PTR_W-1:0]  count;
  logic              full, push, flush_req;
  logic [1:0]        pop;
  logic [IDX_W-1:0]  rd_idx [2];
  rob_pkg::op_kind_e rd_kind [2];
  logic [REG_W-1:0]  rd_dest [2];
  logic [DATA_W-1:0] rd_val  [2];
  logic [ADDR_W-1:0] rd_addr [2];
  logic [1:0]        rd_done, rd_misp;

  assign alloc_ready = !full;
  assign alloc_tag   = tail_idx;
  assign push        = alloc_valid && !full;
  assign rd_idx[0]   = head_idx;
  assign rd_idx[1]   = head_idx + IDX_W'(1);

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .push_i(push), .pop_i(pop), .flush_i(flush_req),
    .head_idx_o(head_idx), .tail_idx_o(tail_idx), .count_o(count), .full_o(full)
  );

  rob_entries #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                .WB_PORTS(WB_PORTS)) u_entries (
    .clk(clk), .rst(rst),
    .alloc_we_i(push), .alloc_idx_i(tail_idx),
    .alloc_kind_i(rob_pkg::op_kind_e'(alloc_kind)), .alloc_dest_i(alloc_dest),
    .wb_valid_i(wb_valid), .wb_tag_i(wb_tag), .wb_value_i(wb_value),
    .wb_addr_i(wb_addr), .wb_misp_i(wb_mispredict), .flush_i(flush_req),
    .rd_idx_i(rd_idx), .rd_kind_o(rd_kind), .rd_dest_o(rd_dest),
    .rd_val_o(rd_val), .rd_addr_o(rd_addr), .rd_done_o(rd_done), .rd_misp_o(rd_misp)
  );

  rob_retire #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_retire (
    .clk(clk), .rst(rst), .count_i(count),
    .kind_i(rd_kind), .dest_i(rd_dest), .val_i(rd_val), .addr_i(rd_addr),
    .done_i(rd_done), .misp_i(rd_misp),
    .pop_o(pop), .flush_req_o(flush_req),
    .rf_we_o(cm_rf_we), .rf_idx_o(cm_rf_idx), .rf_data_o(cm_rf_data),
    .st_we_o(cm_st_we), .st_addr_o(cm_st_addr), .st_data_o(cm_st_data),
    .flush_o(flush)
  );

  // R8: the buffer is empty while the discard pulse is visible
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (rst)
    flush |-> (count == '0));

  for (genvar p = 0; p < WB_PORTS; p++) begin : g_live
    logic [IDX_W-1:0] wb_off;
    assign wb_off = wb_tag[p*IDX_W +: IDX_W] - head_idx;
    // R4: results only target live slots
    a_r4_wb_live: assert property (@(posedge clk) disable iff (rst)
      wb_valid[p] |-> ({1'b0, wb_off} < count));
  end
endmodule

// File: tb/rob_core_bench.sv
`timescale 1ns/1ps
module rob_core_bench;
  localparam int DEPTH = 8, REG_W = 5, DATA_W = 32, ADDR_W = 16, WBP = 2;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic                    alloc_valid = 1'b0;
  logic [1:0]              alloc_kind = '0;
  logic [REG_W-1:0]        alloc_dest = '0;
  logic                    alloc_ready;
  logic [IDX_W-1:0]        alloc_tag;
  logic [WBP-1:0]          wb_valid = '0;
  logic [WBP*IDX_W-1:0]    wb_tag = '0;
  logic [WBP*DATA_W-1:0]   wb_value = '0;
  logic [WBP*ADDR_W-1:0]   wb_addr = '0;
  logic [WBP-1:0]          wb_mispredict = '0;
  logic [1:0]              cm_rf_we, cm_st_we;
  logic [2*REG_W-1:0]      cm_rf_idx;
  logic [2*DATA_W-1:0]     cm_rf_data, cm_st_data;
  logic [2*ADDR_W-1:0]     cm_st_addr;
  logic                    flush;

  rob_core u_rob_core (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_kind(alloc_kind),
    .alloc_dest(alloc_dest), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value), .wb_addr(wb_addr),
    .wb_mispredict(wb_mispredict), .cm_rf_we(cm_rf_we), .cm_rf_idx(cm_rf_idx),
    .cm_rf_data(cm_rf_data), .cm_st_we(cm_st_we), .cm_st_addr(cm_st_addr),
    .cm_st_data(cm_st_data), .flush(flush)
  );

  typedef struct packed {
    logic        st;
    logic [15:0] loc;
    logic [31:0] data;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0, failures = 0;
  int commit_cnt = 0, dual_cnt = 0, flush_cnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard for every architectural write, oldest slot first.
  always @(negedge clk) begin
    if (!rst) begin
      if (flush) flush_cnt++;
      if ((cm_rf_we[0] | cm_st_we[0]) && (cm_rf_we[1] | cm_st_we[1])) dual_cnt++;
      for (int s = 0; s < 2; s++) begin
        if (cm_rf_we[s] || cm_st_we[s]) begin
          exp_t e;
          commit_cnt++;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R8", "write from a discarded or unknown slot", s, -1);
          end else begin
            e = exp_q.pop_front();
            chk(cm_st_we[s] == e.st, "R7", "write kind", cm_st_we[s], e.st);
            if (e.st) begin
              chk(cm_st_addr[s*ADDR_W +: ADDR_W] == e.loc, "R7", "store address",
                  cm_st_addr[s*ADDR_W +: ADDR_W], e.loc);
              chk(cm_st_data[s*DATA_W +: DATA_W] == e.data, "R7", "store data",
                  cm_st_data[s*DATA_W +: DATA_W], e.data);
            end else begin
              chk(cm_rf_idx[s*REG_W +: REG_W] == e.loc[REG_W-1:0], "R7", "register index",
                  cm_rf_idx[s*REG_W +: REG_W], e.loc);
              chk(cm_rf_data[s*DATA_W +: DATA_W] == e.data, "R4", "register value",
                  cm_rf_data[s*DATA_W +: DATA_W], e.data);
            end
          end
        end
      end
    end
  end

  task automatic clear_in();
    alloc_valid = 1'b0;
    wb_valid = '0;
    wb_mispredict = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      clear_in();
    end
  endtask

  task automatic do_alloc(input int kind, input int dest, output int tag);
    @(negedge clk);
    clear_in();
    alloc_valid = 1'b1;
    alloc_kind  = kind[1:0];
    alloc_dest  = dest[REG_W-1:0];
    tag = int'(alloc_tag);
  endtask

  task automatic set_port(input int p, input int tag, input longint val,
                          input int addr, input bit misp);
    wb_valid[p] = 1'b1;
    wb_tag[p*IDX_W +: IDX_W]     = tag[IDX_W-1:0];
    wb_value[p*DATA_W +: DATA_W] = val[DATA_W-1:0];
    wb_addr[p*ADDR_W +: ADDR_W]  = addr[ADDR_W-1:0];
    wb_mispredict[p] = misp;
  endtask

  task automatic do_wb1(input int p, input int tag, input longint val,
                        input int addr, input bit misp);
    @(negedge clk);
    clear_in();
    set_port(p, tag, val, addr, misp);
  endtask

  task automatic do_wb2(input int ta, input longint va, input int aa,
                        input int tb, input longint vb, input int ab);
    @(negedge clk);
    clear_in();
    set_port(0, ta, va, aa, 1'b0);
    set_port(1, tb, vb, ab, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int tag;
    int tags[8];
    int base_commit;
    int base_dual;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: empty after reset
    chk(alloc_ready == 1'b1, "R1", "ready after reset", alloc_ready, 1);
    chk(alloc_tag == '0, "R1", "tag after reset", alloc_tag, 0);
    chk(cm_rf_we == 2'b00 && cm_st_we == 2'b00, "R1", "no write after reset",
        {cm_rf_we, cm_st_we}, 0);
    chk(flush == 1'b0, "R1", "no flush after reset", flush, 0);

    // Fill the whole buffer; slot 3 is a store (R2, R3)
    for (int i = 0; i < DEPTH; i++) begin
      chk(alloc_ready == 1'b1, "R2", "ready below capacity", alloc_ready, 1);
      do_alloc((i == 3) ? 1 : 0, i + 1, tag);
      chk(tag == i, "R3", "sequential tag", tag, i);
      if (i == 3) exp_q.push_back({1'b1, 16'h0040, 32'h0000BEEF});
      else        exp_q.push_back({1'b0, 16'(i + 1), 32'hA000 + 32'(i)});
    end
    idle(1);
    chk(alloc_ready == 1'b0, "R2", "ready low when full", alloc_ready, 0);

    // Complete youngest first; the oldest stays pending (R5, R4)
    do_wb2(7, 32'hA007, 0, 6, 32'hA006, 0);
    do_wb2(5, 32'hA005, 0, 4, 32'hA004, 0);
    do_wb2(3, 32'hBEEF, 16'h0040, 2, 32'hA002, 0);
    idle(3);
    chk(commit_cnt == 0, "R5", "no retire while oldest incomplete", commit_cnt, 0);
    chk(alloc_ready == 1'b0, "R2", "still full while blocked", alloc_ready, 0);
    do_wb2(1, 32'hA001, 0, 0, 32'hA000, 0);
    idle(6);
    chk(commit_cnt == 8, "R6", "all eight retired", commit_cnt, 8);
    chk(dual_cnt == 4, "R6", "two per cycle when both complete", dual_cnt, 4);
    chk(alloc_ready == 1'b1 && alloc_tag == '0, "R2", "empty after wrap of tail",
        {alloc_ready, alloc_tag}, 8);

    // Mispredicted branch behind a complete register op (R8, R6)
    base_dual = dual_cnt;
    do_alloc(0, 9, tag);  exp_q.push_back({1'b0, 16'd9, 32'h00001111});
    do_alloc(2, 0, tag);
    do_alloc(0, 12, tag);
    do_alloc(1, 0, tag);
    do_wb2(2, 32'h5555, 0, 3, 32'h6666, 16'h0080);
    do_wb1(1, 1, 0, 0, 1'b1);
    do_wb1(0, 0, 32'h1111, 0, 1'b0);
    idle(5);
    chk(flush_cnt == 1, "R8", "single flush pulse", flush_cnt, 1);
    chk(commit_cnt == 9, "R8", "only the older op retired", commit_cnt, 9);
    chk(dual_cnt == base_dual, "R6", "no second slot beside mispredicted branch",
        dual_cnt, base_dual);
    chk(alloc_tag == 3'd2, "R8", "tag after flush follows the branch", alloc_tag, 2);
    chk(alloc_ready == 1'b1, "R8", "ready after flush", alloc_ready, 1);
    chk(exp_q.size() == 0, "R8", "scoreboard drained", exp_q.size(), 0);

    // Correctly predicted branch retires with no write, no flush (R7)
    base_commit = commit_cnt;
    do_alloc(2, 0, tag);
    do_alloc(0, 7, tag);  exp_q.push_back({1'b0, 16'd7, 32'h00002222});
    do_wb2(3, 32'h2222, 0, 2, 0, 0);
    idle(3);
    chk(commit_cnt == base_commit + 1, "R7", "branch adds no write",
        commit_cnt, base_commit + 1);
    chk(flush_cnt == 1, "R7", "good branch does not flush", flush_cnt, 1);

    // Refill from mid-buffer so the pointers wrap (R2, R3)
    for (int i = 0; i < DEPTH; i++) begin
      do_alloc(0, 10 + i, tags[i]);
      chk(tags[i] == (4 + i) % DEPTH, "R3", "wrapped tag", tags[i], (4 + i) % DEPTH);
      exp_q.push_back({1'b0, 16'(10 + i), 32'h3000 + 32'(i)});
    end
    idle(1);
    chk(alloc_ready == 1'b0, "R2", "full after wrap", alloc_ready, 0);
    for (int i = 0; i < DEPTH; i += 2)
      do_wb2(tags[i+1], 32'h3000 + i + 1, 0, tags[i], 32'h3000 + i, 0);
    idle(8);
    chk(commit_cnt == base_commit + 9, "R6", "wrapped entries retired",
        commit_cnt, base_commit + 9);
    chk(alloc_ready == 1'b1 && alloc_tag == 3'd4, "R2", "empty after second wrap",
        {alloc_ready, alloc_tag}, 12);
    chk(exp_q.size() == 0, "R5", "every expected write seen", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule